// File: doc/BRIEF.md
# Output Shift Register with Automatic Refill

This block holds one 32-bit data word and hands it out to a pin driver a few bits at a time. A sequencer issues shift commands, each naming a bit count from 1 to 32. The bits taken are presented right-justified on `pin_data` one cycle later, with a one-cycle `pin_valid` pulse. A direction setting chooses whether bits leave from the top or the bottom end of the register. A usage counter records how many bits have left since the last load.

Words come from a host write port into a small transmit queue. The queue holds 4 words, or 8 when it is joined with the neighbouring receive storage. The register takes a new word in two cases: an explicit load command, or, with automatic refill enabled, a shift command that arrives once the usage counter has reached the programmed threshold. A refill that finds the queue empty raises `stall` and freezes the block until a word arrives. In hold mode, the last pin value stays in place once the register is exhausted.

Top module: `osr_autopull`

## Requirements
- R1: After reset the queue is empty (`fifo_empty`=1, `fifo_level`=0), `pin_data`=0, `pin_valid`=0 and `stall`=0. The register counts as exhausted (32 bits used).
- R2: With `cfg_join`=0 the queue holds 4 words and `fifo_full` is set at level 4. A write while full is dropped. Words leave in the order they were written.
- R3: With `cfg_join`=1 the queue holds 8 words and `fifo_full` is set at level 8.
- R4: With `cfg_shift_right`=0, a shift of n bits puts the n most significant register bits on `pin_data[n-1:0]` (upper bits zero). The register then moves left by n and fills with zeros.
- R5: With `cfg_shift_right`=1, a shift of n bits puts the n least significant register bits on `pin_data[n-1:0]`. The register then moves right by n.
- R6: `out_count`=0 means 32 bits. A 32-bit shift empties the register. The usage counter saturates at 32.
- R7: With `cfg_autopull`=1, a shift command arriving when the usage count is at or above the threshold first loads the queue head. It then shifts from that new word, and the count restarts from zero. A threshold of 0 means 32.
- R8: When a refill is needed and the queue is empty, `stall` is raised in the same cycle. The register, counter and pins keep their values and `pin_valid` stays low. The command completes in the cycle after a word has been written.
- R9: An explicit load (`pull_req`) takes the queue head whatever the threshold, and clears the usage count. With an empty queue it raises `stall`.
- R10: With `cfg_autopull`=0 and the register exhausted, a shift leaves `pin_data` unchanged when `cfg_sticky`=1, and drives zero when `cfg_sticky`=0.
- R11: With `cfg_autopull`=0 a shift never takes a word from the queue, whatever the usage count.
- R12: Each completed shift gives exactly one `pin_valid` pulse in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host writes `wr_data` into the queue |
| wr_data | input | 32 | Word to enqueue |
| cfg_join | input | 1 | 1: queue depth 8, 0: depth 4 |
| cfg_shift_right | input | 1 | 1: bits leave from the LSB end, 0: from the MSB end |
| cfg_autopull | input | 1 | Enables refill at the threshold |
| cfg_thresh | input | 5 | Refill threshold in bits, 0 means 32 |
| cfg_sticky | input | 1 | Hold last pin value when register is exhausted |
| out_req | input | 1 | Shift command |
| out_count | input | 5 | Bits to shift, 0 means 32 |
| pull_req | input | 1 | Explicit load command |
| pin_data | output | 32 | Bits of the last shift, right-justified |
| pin_valid | output | 1 | Pulse: `pin_data` updated by a shift |
| stall | output | 1 | Command waiting on an empty queue |
| fifo_full | output | 1 | Queue at capacity |
| fifo_empty | output | 1 | Queue holds no word |
| fifo_level | output | 4 | Words in the queue |

## Verification
The assertions assume that `out_req` and `pull_req` are never high in the same cycle. They also assume that `cfg_join` changes only while the queue is at or below 4 words, so the level never exceeds the active capacity. The bench issues one command per task call and drops each request after one edge. The only command it holds over several cycles is the stalled shift, and that is waiting on the queue. It switches the join setting only after the queue has been drained.

// File: rtl/osr_autopull.sv
module osr_autopull #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_valid,
  input  logic [W-1:0]                wr_data,
  input  logic                        cfg_join,
  input  logic                        cfg_shift_right,
  input  logic                        cfg_autopull,
  input  logic [$clog2(W)-1:0]        cfg_thresh,
  input  logic                        cfg_sticky,
  input  logic                        out_req,
  input  logic [$clog2(W)-1:0]        out_count,
  input  logic                        pull_req,
  output logic [W-1:0]                pin_data,
  output logic                        pin_valid,
  output logic                        stall,
  output logic                        fifo_full,
  output logic                        fifo_empty,
  output logic [$clog2(2*DEPTH):0]    fifo_level
);
  localparam int SW   = $clog2(W) + 1;
  localparam int MAXD = 2 * DEPTH;
  localparam int PW   = $clog2(MAXD);
  localparam int LW   = PW + 1;

  logic [W-1:0]  mem [MAXD];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [W-1:0]  osr;
  logic [SW-1:0] used;

  wire [LW-1:0] cap = cfg_join ? LW'(MAXD) : LW'(DEPTH);
  assign fifo_full  = fifo_level >= cap;
  assign fifo_empty = fifo_level == '0;

  wire [SW-1:0] n   = (out_count == '0) ? SW'(W) : {1'b0, out_count};
  wire [SW-1:0] thr = (cfg_thresh == '0) ? SW'(W) : {1'b0, cfg_thresh};
  wire need_fill    = cfg_autopull && (used >= thr);
  wire want_load    = pull_req || (out_req && need_fill);
  assign stall      = want_load && fifo_empty;
  wire load         = want_load && !fifo_empty;
  wire do_shift     = out_req && !stall;
  wire push         = wr_valid && !fifo_full;

  wire [W-1:0]    src  = load ? mem[rd_ptr] : osr;
  wire [SW-1:0]   base = load ? '0 : used;
  wire [2*W-1:0]  lft  = {{W{1'b0}}, src} << n;
  wire [2*W-1:0]  rgt  = {src, {W{1'b0}}} >> n;
  wire [W-1:0]    bits = cfg_shift_right ? (rgt[W-1:0] >> (SW'(W) - n)) : lft[2*W-1:W];
  wire [W-1:0]    rest = cfg_shift_right ? rgt[2*W-1:W] : lft[W-1:0];
  wire [SW:0]     sum  = {1'b0, base} + {1'b0, n};
  wire exhausted       = (used == SW'(W)) && !load;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr     <= '0;
      wr_ptr     <= '0;
      fifo_level <= '0;
      osr        <= '0;
      used       <= SW'(W);
      pin_data   <= '0;
      pin_valid  <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (load) rd_ptr <= rd_ptr + 1'b1;
      fifo_level <= fifo_level + LW'(push) - LW'(load);
      pin_valid  <= do_shift;
      if (do_shift) begin
        osr  <= rest;
        used <= (sum > (SW+1)'(W)) ? SW'(W) : sum[SW-1:0];
        if (!(cfg_sticky && exhausted)) pin_data <= bits;
      end else if (load) begin
        osr  <= src;
        used <= '0;
      end
    end
  end

  assert_cmd_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_req && pull_req));
  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= cap);
  assert_stall_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(osr) && $stable(used) && !pin_valid && $stable(pin_data));
  assert_pull_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_req && !fifo_empty) |=> used == '0);
  assert_refill_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && need_fill && !fifo_empty) |=> used == $past(n));
  assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && !cfg_autopull && cfg_sticky && used == SW'(W)) |=> $stable(pin_data));
  assert_no_refill_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_autopull && !pull_req) |=> fifo_level >= $past(fifo_level));
  assert_out_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && !stall) |=> pin_valid);
  assert_valid_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_req && !stall) |=> !pin_valid);
endmodule

// File: tb/osr_autopull_bench.sv
module osr_autopull_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  localparam logic [69:0] VEC [NV] = '{
    {1'b0, 32'h12345678, 5'd4,  32'h00000001},
    {1'b0, 32'h12345678, 5'd8,  32'h00000012},
    {1'b0, 32'h12345678, 5'd12, 32'h00000123},
    {1'b0, 32'h12345678, 5'd0,  32'h12345678},
    {1'b0, 32'h12345678, 5'd1,  32'h00000000},
    {1'b1, 32'h12345678, 5'd4,  32'h00000008},
    {1'b1, 32'h12345678, 5'd8,  32'h00000078},
    {1'b1, 32'h12345678, 5'd16, 32'h00005678},
    {1'b0, 32'hF0000001, 5'd3,  32'h00000007},
    {1'b1, 32'hF0000001, 5'd1,  32'h00000001}
  };

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, cfg_join = 0, cfg_shift_right = 0, cfg_autopull = 0, cfg_sticky = 0;
  logic out_req = 0, pull_req = 0;
  logic [31:0] wr_data = 0;
  logic [4:0] cfg_thresh = 0, out_count = 0;
  logic [31:0] pin_data;
  logic pin_valid, stall, fifo_full, fifo_empty;
  logic [3:0] fifo_level;
  int checks = 0, errors = 0;

  osr_autopull u_osr_autopull (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .cfg_join(cfg_join), .cfg_shift_right(cfg_shift_right), .cfg_autopull(cfg_autopull),
    .cfg_thresh(cfg_thresh), .cfg_sticky(cfg_sticky), .out_req(out_req),
    .out_count(out_count), .pull_req(pull_req), .pin_data(pin_data),
    .pin_valid(pin_valid), .stall(stall), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .fifo_level(fifo_level));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(logic [31:0] w);
    wr_valid = 1; wr_data = w; tick(); wr_valid = 0;
  endtask

  task automatic pull();
    pull_req = 1; tick(); pull_req = 0;
  endtask

  task automatic shift(logic [4:0] c);
    out_req = 1; out_count = c; tick(); out_req = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    check("R1 empty", fifo_empty, 1);
    check("R1 level", fifo_level, 0);
    check("R1 pin_data", pin_data, 0);
    check("R1 pin_valid", pin_valid, 0);
    check("R1 stall", stall, 0);

    for (int i = 0; i < NV; i++) begin
      push(VEC[i][68:37]);
      pull();
      cfg_shift_right = VEC[i][69];
      shift(VEC[i][36:32]);
      check(VEC[i][69] ? "R5 right shift" : "R4 left shift", pin_data, VEC[i][31:0]);
      check("R12 pulse", pin_valid, 1);
      tick();
      check("R12 single pulse", pin_valid, 0);
    end
    cfg_shift_right = 0;

    for (int i = 0; i < 5; i++) push(32'h100 + i);
    check("R2 level", fifo_level, 4);
    check("R2 full", fifo_full, 1);
    for (int i = 0; i < 4; i++) begin
      pull(); shift(5'd0);
      check("R2 order", pin_data, 32'h100 + i);
    end
    check("R2 drop on full", fifo_empty, 1);

    cfg_join = 1;
    for (int i = 0; i < 9; i++) push(32'h200 + i);
    check("R3 level", fifo_level, 8);
    check("R3 full", fifo_full, 1);
    for (int i = 0; i < 8; i++) pull();
    check("R3 drained", fifo_empty, 1);
    cfg_join = 0;

    push(32'h12345678); pull();
    shift(5'd8);  check("R4 first byte", pin_data, 32'h12);
    shift(5'd8);  check("R4 second byte", pin_data, 32'h34);
    shift(5'd16); check("R6 rest", pin_data, 32'h5678);

    cfg_autopull = 1; cfg_thresh = 5'd8;
    push(32'hAABBCCDD); push(32'h11223344);
    pull();
    shift(5'd8); check("R7 before threshold", pin_data, 32'hAA);
    check("R7 no early refill", fifo_level, 1);
    shift(5'd8); check("R7 refill at threshold", pin_data, 32'h11);
    check("R7 popped", fifo_empty, 1);

    cfg_thresh = 5'd0;
    push(32'hCAFEF00D); push(32'h9BADBEEF);
    pull();
    shift(5'd16); check("R7 thr32 a", pin_data, 32'hCAFE);
    shift(5'd8);  check("R7 thr32 b", pin_data, 32'hF0);
    shift(5'd8);  check("R7 thr32 c", pin_data, 32'h0D);
    check("R7 thr32 held", fifo_level, 1);
    shift(5'd4);  check("R7 thr32 refill", pin_data, 32'h9);

    cfg_thresh = 5'd4;
    out_req = 1; out_count = 5'd4; #1;
    check("R8 stall raised", stall, 1);
    tick();
    check("R8 no pulse", pin_valid, 0);
    check("R8 pins held", pin_data, 32'h9);
    wr_valid = 1; wr_data = 32'h5EEDF00D; tick(); wr_valid = 0;
    check("R8 still waiting", pin_valid, 0);
    check("R8 stall drops", stall, 0);
    tick(); out_req = 0;
    check("R8 resumed data", pin_data, 32'h5);
    check("R8 resumed pulse", pin_valid, 1);

    pull_req = 1; #1;
    check("R9 empty pull stalls", stall, 1);
    tick(); pull_req = 0;

    cfg_autopull = 0;
    push(32'h77777777);
    shift(5'd0); check("R6 full shift", pin_data, 32'hEEDF00D0);
    cfg_sticky = 1;
    shift(5'd8); check("R10 sticky hold", pin_data, 32'hEEDF00D0);
    cfg_sticky = 0;
    shift(5'd8); check("R10 non-sticky zero", pin_data, 32'h0);
    check("R11 no refill", fifo_level, 1);

    pull(); shift(5'd4);
    check("R9 pull below threshold", pin_data, 32'h7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule